// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block holds the payload of one SMBus block transfer so that software can move the whole payload at once instead of running a handshake for every byte. Software programs the byte count into a count register. It then streams the payload bytes through one data port register. An internal host index moves to the next entry on every port access. A read of the control register returns that index to entry 0, so the same port can then be used to drain the buffer.

On the bus side, a sequencer pulls transmit bytes out in index order, or it pushes received bytes in. It first delivers the count byte it received. The sequencer keeps a pointer of its own and stops once the count has been served. A count byte outside 1..DEPTH raises an error flag.

An auxiliary control register holds two bits: a buffered-mode enable and a checksum enable. When the buffered-mode enable is clear, the buffer and both of its indexes stand still.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset, reads at offsets 2 (control), 5 (count) and 13 (aux) return 0, and a port read at offset 7 returns 0. The outputs countErr and pecEn are 0, and seqDone is 1.
- R2: With buffered mode on, a host write at offset 7 stores the byte at the host index and advances the index by one. Host reads at offset 7 return the entries in index order and also advance the index.
- R3: Any host read at offset 2 returns the stored control byte and sets the host index to 0, whatever the mode.
- R4: With aux bit 1 clear, port writes store nothing, port reads return 0, and neither the host index nor the sequencer pointer moves. Sequencer strobes (start, pop, count, byte) are ignored.
- R5: The host index stops at DEPTH. At that point port writes are dropped and port reads return 0, until a control read resets the index.
- R6: The aux register at offset 13 keeps bit 0 (checksum enable, driven on pecEn) and bit 1 (buffered-mode enable), and reads other bits as 0.
- R7: seqStart sets the sequencer pointer to 0 and clears countErr. Each seqTxPop presents the next entry on seqTxByte, in index order.
- R8: A seqRxCountVld strobe loads seqRxByte into the count register, which is readable at offset 5. countErr is set when that byte is 0 or greater than DEPTH, and cleared otherwise.
- R9: Each seqRxByteVld writes seqRxByte at the sequencer pointer and advances the pointer. Bytes that arrive after the limit is reached are dropped, and host port reads then return the received bytes.
- R10: The sequencer limit is min(count, DEPTH), or 0 while countErr is set. seqDone is 1 exactly when the pointer has reached the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Register offset of the host access |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (side effects at the clock edge) |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, valid while hostRd is high |
| seqStart | input | 1 | Sequencer begins a transfer |
| seqTxPop | input | 1 | Sequencer consumed seqTxByte |
| seqTxByte | output | 8 | Entry at the sequencer pointer |
| seqRxCountVld | input | 1 | seqRxByte holds the received count |
| seqRxByteVld | input | 1 | seqRxByte holds a received data byte |
| seqRxByte | input | 8 | Received byte from the sequencer |
| seqDone | output | 1 | Sequencer pointer reached the limit |
| countErr | output | 1 | Received count out of range |
| pecEn | output | 1 | Checksum enable bit from the aux register |

## Verification
The bench builds the block with its default DEPTH of 32. That value puts the saturation boundary within short bursts: streams of 33 to 40 bytes cross it. It also makes the out-of-range counts reachable, both 0 and 33 up to 255 from the 8-bit count byte. Random bursts of 1 to 40 bytes land on both sides of the boundary, and the directed cases pin the exact edges at 32 and 33.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  // register offsets the host decodes
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_PORT  = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_AUX   = 4'd13;

  localparam int AUX_PEC_BIT = 0;
  localparam int AUX_BUF_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic portWr;
    logic portRd;
    logic idxClear;
    logic seqClear;
    logic seqAdvance;
    logic seqWr;
  } bufStrobe_t;
endpackage

// File: rtl/smb_blkbuf_ctrl.sv
module smb_blkbuf_ctrl
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] hostRdata,
  input  logic              seqStart,
  input  logic              seqTxPop,
  input  logic              seqRxCountVld,
  input  logic              seqRxByteVld,
  input  logic [BYTE_W-1:0] seqRxByte,
  input  logic [BYTE_W-1:0] portRdData,
  input  logic [IDX_W-1:0]  seqPtr,
  output bufStrobe_t        strobe,
  output logic              seqDone,
  output logic              countErr,
  output logic              bufEn,
  output logic              pecEn
);
  localparam logic [BYTE_W-1:0] DEPTH_B = BYTE_W'(DEPTH);
  localparam logic [IDX_W-1:0]  DEPTH_I = IDX_W'(DEPTH);

  logic [BYTE_W-1:0] ctrlReg;
  logic [BYTE_W-1:0] countReg;
  logic [1:0]        auxReg;
  logic [IDX_W-1:0]  limit;
  logic              countBad;

  assign bufEn    = auxReg[AUX_BUF_BIT];
  assign pecEn    = auxReg[AUX_PEC_BIT];
  assign countBad = (seqRxByte == '0) || (seqRxByte > DEPTH_B);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      countReg <= '0;
      auxReg   <= '0;
      countErr <= 1'b0;
    end else begin
      if (hostWr) begin
        unique case (hostAddr)
          OFS_CTRL:  ctrlReg  <= hostWdata;
          OFS_COUNT: countReg <= hostWdata;
          OFS_AUX:   auxReg   <= hostWdata[1:0];
          default: ;
        endcase
      end
      if (bufEn && seqStart) countErr <= 1'b0;
      if (bufEn && seqRxCountVld) begin
        countReg <= seqRxByte;
        countErr <= countBad;
      end
    end
  end

  // transfer limit for the sequencer side
  always_comb begin
    if (countErr)               limit = '0;
    else if (countReg > DEPTH_B) limit = DEPTH_I;
    else                         limit = countReg[IDX_W-1:0];
  end

  assign seqDone = (seqPtr >= limit);

  always_comb begin
    strobe            = '0;
    strobe.portWr     = bufEn && hostWr && (hostAddr == OFS_PORT);
    strobe.portRd     = bufEn && hostRd && (hostAddr == OFS_PORT);
    strobe.idxClear   = hostRd && (hostAddr == OFS_CTRL);
    strobe.seqClear   = bufEn && seqStart;
    strobe.seqAdvance = bufEn && !seqStart && !seqDone && (seqTxPop || seqRxByteVld);
    strobe.seqWr      = bufEn && !seqStart && !seqDone && seqRxByteVld;
  end

  always_comb begin
    unique case (hostAddr)
      OFS_CTRL:  hostRdata = ctrlReg;
      OFS_COUNT: hostRdata = countReg;
      OFS_PORT:  hostRdata = bufEn ? portRdData : '0;
      OFS_AUX:   hostRdata = {{(BYTE_W-2){1'b0}}, auxReg};
      default:   hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/smb_blkbuf_dpath.sv
module smb_blkbuf_dpath
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [BYTE_W-1:0] hostWdata,
  input  logic [BYTE_W-1:0] seqRxByte,
  output logic [BYTE_W-1:0] portRdData,
  output logic [BYTE_W-1:0] seqTxByte,
  output logic [IDX_W-1:0]  hostIdx,
  output logic [IDX_W-1:0]  seqPtr
);
  localparam int            SLOT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  logic [DEPTH-1:0][BYTE_W-1:0] slotQ;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [BYTE_W-1:0] slotReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotReg <= '0;
      else if (strobe.portWr && (hostIdx == IDX_W'(e)))
        slotReg <= hostWdata;
      else if (strobe.seqWr && (seqPtr == IDX_W'(e)))
        slotReg <= seqRxByte;
    end
    assign slotQ[e] = slotReg;
  end

  // host index: clear wins, then saturating advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hostIdx <= '0;
    else if (strobe.idxClear)
      hostIdx <= '0;
    else if ((strobe.portWr || strobe.portRd) && (hostIdx < DEPTH_I))
      hostIdx <= hostIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      seqPtr <= '0;
    else if (strobe.seqClear)
      seqPtr <= '0;
    else if (strobe.seqAdvance && (seqPtr < DEPTH_I))
      seqPtr <= seqPtr + 1'b1;
  end

  assign portRdData = (hostIdx < DEPTH_I) ? slotQ[hostIdx[SLOT_W-1:0]] : '0;
  assign seqTxByte  = (seqPtr  < DEPTH_I) ? slotQ[seqPtr[SLOT_W-1:0]]  : '0;
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       seqStart,
  input  logic       seqTxPop,
  output logic [7:0] seqTxByte,
  input  logic       seqRxCountVld,
  input  logic       seqRxByteVld,
  input  logic [7:0] seqRxByte,
  output logic       seqDone,
  output logic       countErr,
  output logic       pecEn
);
  localparam int IDX_W = $clog2(DEPTH) + 1;

  bufStrobe_t        strobe;
  logic [BYTE_W-1:0] portRdData;
  logic [IDX_W-1:0]  hostIdx;
  logic [IDX_W-1:0]  seqPtr;
  logic              bufEn;

  smb_blkbuf_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .seqStart(seqStart), .seqTxPop(seqTxPop),
    .seqRxCountVld(seqRxCountVld), .seqRxByteVld(seqRxByteVld),
    .seqRxByte(seqRxByte), .portRdData(portRdData), .seqPtr(seqPtr),
    .strobe(strobe), .seqDone(seqDone), .countErr(countErr),
    .bufEn(bufEn), .pecEn(pecEn)
  );

  smb_blkbuf_dpath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostWdata(hostWdata), .seqRxByte(seqRxByte),
    .portRdData(portRdData), .seqTxByte(seqTxByte),
    .hostIdx(hostIdx), .seqPtr(seqPtr)
  );
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       hostAddr,
  input logic             hostWr,
  input logic             hostRd,
  input logic             seqStart,
  input logic             seqRxCountVld,
  input logic [7:0]       seqRxByte,
  input logic             countErr,
  input logic             bufEn,
  input logic [IDX_W-1:0] hostIdx,
  input logic [IDX_W-1:0] seqPtr
);
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);
  localparam logic [7:0]       DEPTH_B = 8'(DEPTH);

  logic ctrlRead;
  assign ctrlRead = hostRd && (hostAddr == OFS_CTRL);

  p_idx_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRead |=> (hostIdx == '0));

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && hostWr && !hostRd && (hostAddr == OFS_PORT) && (hostIdx < DEPTH_I))
      |=> (hostIdx == $past(hostIdx) + 1'b1));

  p_idle_host_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEn && !ctrlRead) |=> $stable(hostIdx));

  p_idle_seq_r4: assert property (@(posedge clk) disable iff (!rstN)
    !bufEn |=> $stable(seqPtr));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((hostIdx == DEPTH_I) && !ctrlRead) |=> (hostIdx == DEPTH_I));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && seqStart) |=> (seqPtr == '0));

  p_bad_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bufEn && seqRxCountVld && ((seqRxByte == '0) || (seqRxByte > DEPTH_B)))
      |=> countErr);

  p_ptr_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seqPtr <= DEPTH_I) && (hostIdx <= DEPTH_I));
endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostRd(hostRd), .seqStart(seqStart), .seqRxCountVld(seqRxCountVld),
  .seqRxByte(seqRxByte), .countErr(countErr), .bufEn(bufEn),
  .hostIdx(hostIdx), .seqPtr(seqPtr)
);

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam logic [3:0] A_CTRL = 4'd2, A_COUNT = 4'd5, A_PORT = 4'd7, A_AUX = 4'd13;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic seqStart = 1'b0, seqTxPop = 1'b0, seqRxCountVld = 1'b0, seqRxByteVld = 1'b0;
  logic [7:0] seqRxByte = '0, seqTxByte;
  logic seqDone, countErr, pecEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_blkbuf #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .seqStart(seqStart),
    .seqTxPop(seqTxPop), .seqTxByte(seqTxByte), .seqRxCountVld(seqRxCountVld),
    .seqRxByteVld(seqRxByteVld), .seqRxByte(seqRxByte), .seqDone(seqDone),
    .countErr(countErr), .pecEn(pecEn)
  );

  int nChecks = 0, nFails = 0;
  int mBuf [DEPTH];
  int mIdx = 0, mPtr = 0, mCount = 0, mAux = 0, mCtrl = 0;
  bit mErr = 1'b0;

  function automatic bit enOn();
    return mAux[1];
  endfunction

  function automatic int limitOf();
    if (mErr) return 0;
    return (mCount > DEPTH) ? DEPTH : mCount;
  endfunction

  function automatic int expRead(input logic [3:0] a);
    case (a)
      A_CTRL:  return mCtrl;
      A_COUNT: return mCount;
      A_AUX:   return mAux;
      A_PORT:  return (enOn() && mIdx < DEPTH) ? mBuf[mIdx] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] a, input int d);
    @(negedge clk); hostAddr = a; hostWdata = 8'(d); hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
    case (a)
      A_CTRL:  mCtrl = d & 8'hff;
      A_COUNT: mCount = d & 8'hff;
      A_AUX:   mAux = d & 3;
      A_PORT:  if (enOn() && mIdx < DEPTH) begin mBuf[mIdx] = d & 8'hff; mIdx++; end
      default: ;
    endcase
  endtask

  task automatic hostRead(input logic [3:0] a, input string tag);
    int exp;
    exp = expRead(a);
    @(negedge clk); hostAddr = a; hostRd = 1'b1;
    #1 check(tag, int'(hostRdata), exp);
    @(negedge clk); hostRd = 1'b0;
    if (a == A_CTRL) mIdx = 0;
    if (a == A_PORT && enOn() && mIdx < DEPTH) mIdx++;
  endtask

  task automatic seqStartPulse();
    @(negedge clk); seqStart = 1'b1;
    @(negedge clk); seqStart = 1'b0;
    if (enOn()) begin mPtr = 0; mErr = 1'b0; end
  endtask

  task automatic seqCount(input int c);
    @(negedge clk); seqRxByte = 8'(c); seqRxCountVld = 1'b1;
    @(negedge clk); seqRxCountVld = 1'b0;
    if (enOn()) begin mCount = c; mErr = (c == 0 || c > DEPTH); end
  endtask

  task automatic seqPush(input int b);
    @(negedge clk); seqRxByte = 8'(b); seqRxByteVld = 1'b1;
    @(negedge clk); seqRxByteVld = 1'b0;
    if (enOn() && mPtr < limitOf()) begin mBuf[mPtr] = b; mPtr++; end
  endtask

  task automatic seqPop();
    @(negedge clk); seqTxPop = 1'b1;
    @(negedge clk); seqTxPop = 1'b0;
    if (enOn() && mPtr < limitOf()) mPtr++;
  endtask

  task automatic seqCheck(input string tag);
    @(negedge clk); #1;
    check({tag, " seqDone"}, int'(seqDone), int'(mPtr >= limitOf()));
    check({tag, " countErr"}, int'(countErr), int'(mErr));
    if (mPtr < limitOf()) check({tag, " seqTxByte"}, int'(seqTxByte), mBuf[mPtr]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1c));
    for (int i = 0; i < DEPTH; i++) mBuf[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    seqCheck("R1");
    check("R1 pecEn", int'(pecEn), 0);
    hostRead(A_CTRL, "R1 ctrl");
    hostRead(A_COUNT, "R1 count");
    hostRead(A_AUX, "R1 aux");
    hostRead(A_PORT, "R1 port");

    // R4 disabled: writes dropped, index frozen, sequencer ignored
    hostWrite(A_PORT, 8'hA5);
    hostWrite(A_PORT, 8'h5A);
    seqCount(3);
    seqPush(8'h77);
    hostRead(A_PORT, "R4 disabled read");
    hostRead(A_COUNT, "R4 count unchanged");
    hostWrite(A_AUX, 8'h02);
    hostRead(A_PORT, "R4 slot0 untouched");
    hostRead(A_PORT, "R4 index did not move");

    // R6 aux bits
    hostWrite(A_AUX, 8'hFF);
    hostRead(A_AUX, "R6 aux readback");
    check("R6 pecEn", int'(pecEn), 1);
    hostWrite(A_AUX, 8'h02);
    check("R6 pecEn clear", int'(pecEn), 0);

    // R2 / R3 ordered write and drain
    hostRead(A_CTRL, "R3 ctrl read");
    for (int i = 0; i < 6; i++) hostWrite(A_PORT, 8'h10 + i);
    hostWrite(A_CTRL, 8'h3C);
    hostRead(A_CTRL, "R3 ctrl resets index");
    for (int i = 0; i < 6; i++) hostRead(A_PORT, "R2 ordered read");

    // R5 saturation at DEPTH
    hostRead(A_CTRL, "R3 ctrl read");
    for (int i = 0; i < DEPTH + 3; i++) hostWrite(A_PORT, 8'h80 + i);
    hostRead(A_PORT, "R5 saturated read is zero");
    hostRead(A_CTRL, "R3 ctrl read");
    for (int i = 0; i < DEPTH + 1; i++) hostRead(A_PORT, "R5 drain after saturation");

    // R8 count range
    seqCount(0);   seqCheck("R8 count 0");
    seqCount(33);  seqCheck("R8 count 33");
    seqStartPulse(); seqCheck("R7 start clears error");
    seqCount(32);  seqCheck("R8 count 32");
    seqCount(1);   seqCheck("R8 count 1");
    hostRead(A_COUNT, "R8 count readback");

    // R9 receive stops at the count
    seqStartPulse();
    seqCount(5);
    for (int i = 0; i < 7; i++) seqPush(8'hC0 + i);
    seqCheck("R9 rx stopped");
    hostRead(A_CTRL, "R3 ctrl read");
    for (int i = 0; i < 7; i++) hostRead(A_PORT, "R9 rx drain");

    // R10 transmit limit clamps at DEPTH
    hostWrite(A_COUNT, 40);
    seqStartPulse();
    for (int i = 0; i < DEPTH + 2; i++) begin
      seqCheck("R10 tx clamp");
      seqPop();
    end
    seqCheck("R10 tx done");

    // random mix
    for (int it = 0; it < 25; it++) begin
      int n, c;
      n = 1 + int'($urandom_range(0, 39));
      c = int'($urandom_range(0, 40));
      if ($urandom_range(0, 5) == 0) hostWrite(A_AUX, 0); else hostWrite(A_AUX, 2);
      hostRead(A_CTRL, "R3 rand ctrl");
      for (int i = 0; i < n; i++) hostWrite(A_PORT, int'($urandom_range(0, 255)));
      hostRead(A_CTRL, "R3 rand ctrl");
      for (int i = 0; i < 4; i++) hostRead(A_PORT, "R2 rand read");
      if (it[0]) begin
        hostWrite(A_COUNT, c);
        seqStartPulse();
        for (int i = 0; i < c + 1; i++) begin seqCheck("R7 rand tx"); seqPop(); end
      end else begin
        seqStartPulse();
        seqCount(c);
        for (int i = 0; i < n; i++) seqPush(int'($urandom_range(0, 255)));
        seqCheck("R9 rand rx");
        hostRead(A_CTRL, "R3 rand ctrl");
        for (int i = 0; i < 8; i++) hostRead(A_PORT, "R9 rand drain");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule